// File: doc/BRIEF.md
# Synchronous Dual-Port Memory Port Control

This block is an 8-bit synchronous memory with two independent access ports, called left and right. Each port has its own clock and reset. Each port also has two chip enables of opposite polarity, a read/write select, an output enable that acts without a clock, an address, write data, and read data with a drive flag. A mode input on each port sets the read latency. In flow-through mode the data follows the capturing edge. In pipelined mode it follows one edge later.

High-impedance pads are not modelled. Each port raises a drive flag whenever it would drive its data lines, and holds its read data at zero while the flag is low. In pipelined mode the port select passes through two register stages and the read state follows it, so a deselect reaches the outputs one cycle later than in flow-through mode.

Both ports can write the same word on coinciding edges. In that case the right port's value is kept. A read that coincides with a write to the same word from the other port returns the word as it was before that write.

Top module: `sync_dpram`

## Requirements
- R1: While a port's reset is low, and straight after it is released, that port's drive flag is 0 and its read data is 0.
- R2: A port counts as selected at a rising clock edge only when chip enable 0 is low and chip enable 1 is high. At any other edge it neither writes nor drives data.
- R3: When a port is selected and read/write is 0 at a rising edge, its write data is stored at its address.
- R4: In flow-through mode (mode input 0), a selected read (read/write 1) at edge k with output enable low gives a drive flag of 1 and the stored word on the read data between edge k and edge k+1.
- R5: In pipelined mode (mode input 1), the word read at edge k appears, with the drive flag at 1, between edge k+1 and edge k+2. The drive flag is still 0 between edge k and edge k+1 when the port was idle before edge k.
- R6: Output enable high drops the drive flag and the read data to 0 at once, with no clock edge, and output enable low restores them.
- R7: A port deselected at edge k stops driving after edge k in flow-through mode. In pipelined mode it stops driving only after edge k+1.
- R8: A word written through one port can be read through the other port.
- R9: When both ports write the same address on the same edge, the right port's data is the value stored.
- R10: A read at the same edge as a write to the same address from the other port returns the value held before that write.
- R11: Whenever the drive flag is 0, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port reset, active low |
| ce0n_l | input | 1 | Left chip enable, active low |
| ce1_l | input | 1 | Left chip enable, active high |
| rw_l | input | 1 | Left read (1) or write (0) |
| oen_l | input | 1 | Left output enable, active low, unclocked |
| pipe_l | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| addr_l | input | ADDR_W | Left address |
| din_l | input | DATA_W | Left write data |
| dout_l | output | DATA_W | Left read data, 0 when not driving |
| drive_l | output | 1 | Left drive flag |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port reset, active low |
| ce0n_r | input | 1 | Right chip enable, active low |
| ce1_r | input | 1 | Right chip enable, active high |
| rw_r | input | 1 | Right read (1) or write (0) |
| oen_r | input | 1 | Right output enable, active low, unclocked |
| pipe_r | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| addr_r | input | ADDR_W | Right address |
| din_r | input | DATA_W | Right write data |
| dout_r | output | DATA_W | Right read data, 0 when not driving |
| drive_r | output | 1 | Right drive flag |

## Verification
Writes take effect at the edge that captures them. A flow-through read is due one nanosecond after its edge, and a pipelined read is due one edge later. A deselect needs the same extra edge in pipelined mode. Output enable is checked with no clock edge at all: the bench changes it between edges, waits a fraction of a nanosecond and looks again. The bench drives all inputs after an edge and samples one nanosecond after the edge it is waiting for, so each check names the edge whose effect it reads.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;

  // select decode: low-active enable 0 together with high-active enable 1
  function automatic logic port_hit(input logic ce_n, input logic ce);
    return !ce_n && ce;
  endfunction

  // drive decision: registered select, registered read, live output enable
  function automatic logic drive_on(input logic sel_q, input logic rd_q,
                                    input logic oe_n);
    return sel_q && rd_q && !oe_n;
  endfunction

endpackage

// File: rtl/sdp_store.sv
module sdp_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_l,
  input  logic              we_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] din_l,
  output logic [DATA_W-1:0] word_l,
  input  logic              clk_r,
  input  logic              we_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] word_r
);
  localparam int DEPTH = 1 << ADDR_W;

  // Each bank is written only from its own clock domain.
  // The stored word is the XOR of the two banks.
  logic [DATA_W-1:0] bank_l [DEPTH];
  logic [DATA_W-1:0] bank_r [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bank_l[i] = '0;
      bank_r[i] = '0;
    end
  end

  // a collision on coinciding edges lets the right side win
  logic clash, we_l_eff;
  assign clash    = we_l && we_r && (addr_l == addr_r);
  assign we_l_eff = we_l && !clash;

  always_ff @(posedge clk_l) begin
    if (we_l_eff) bank_l[addr_l] <= din_l ^ bank_r[addr_l];
  end

  always_ff @(posedge clk_r) begin
    if (we_r) bank_r[addr_r] <= din_r ^ bank_l[addr_r];
  end

  assign word_l = bank_l[addr_l] ^ bank_r[addr_l];
  assign word_r = bank_l[addr_r] ^ bank_r[addr_r];

endmodule

// File: rtl/sdp_port.sv
module sdp_port
  import sdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              rw,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [DATA_W-1:0] word,
  output logic              we,
  output logic [DATA_W-1:0] dq,
  output logic              dq_oe
);
  localparam int STAGES = 2;

  logic hit, rd_req;
  assign hit    = port_hit(ce_n, ce);
  assign we     = hit && !rw;
  assign rd_req = hit && rw;

  logic              sel_st [STAGES];
  logic              rd_st  [STAGES];
  logic [DATA_W-1:0] dat_st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_st[0] <= 1'b0;
      rd_st[0]  <= 1'b0;
      dat_st[0] <= '0;
    end else begin
      sel_st[0] <= hit;
      rd_st[0]  <= rd_req;
      if (rd_req) dat_st[0] <= word;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_st[s] <= 1'b0;
        rd_st[s]  <= 1'b0;
        dat_st[s] <= '0;
      end else begin
        sel_st[s] <= sel_st[s-1];
        rd_st[s]  <= rd_st[s-1];
        dat_st[s] <= dat_st[s-1];
      end
    end
  end

  rd_mode_e          mode;
  logic              sel_o, rd_o;
  logic [DATA_W-1:0] dat_o;
  assign mode  = rd_mode_e'(pipe);
  assign sel_o = (mode == RD_PIPE) ? sel_st[STAGES-1] : sel_st[0];
  assign rd_o  = (mode == RD_PIPE) ? rd_st[STAGES-1]  : rd_st[0];
  assign dat_o = (mode == RD_PIPE) ? dat_st[STAGES-1] : dat_st[0];

  assign dq_oe = drive_on(sel_o, rd_o, oe_n);
  assign dq    = dq_oe ? dat_o : '0;

  // R4
  flow_read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && rd_req) |=> (pipe || oe_n || dq_oe));

  // R7
  flow_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && !hit) |=> (pipe || !dq_oe));

  // R7
  pipe_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && !hit) ##1 pipe |=> !dq_oe);

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R11
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq == '0));

endmodule

// File: rtl/sync_dpram.sv
module sync_dpram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_l,
  input  logic              rst_l_n,
  input  logic              ce0n_l,
  input  logic              ce1_l,
  input  logic              rw_l,
  input  logic              oen_l,
  input  logic              pipe_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] din_l,
  output logic [DATA_W-1:0] dout_l,
  output logic              drive_l,
  input  logic              clk_r,
  input  logic              rst_r_n,
  input  logic              ce0n_r,
  input  logic              ce1_r,
  input  logic              rw_r,
  input  logic              oen_r,
  input  logic              pipe_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] dout_r,
  output logic              drive_r
);
  logic              we_l, we_r;
  logic [DATA_W-1:0] word_l, word_r;

  sdp_port #(.DATA_W(DATA_W)) u_left (
    .clk(clk_l), .rst_n(rst_l_n), .ce_n(ce0n_l), .ce(ce1_l), .rw(rw_l),
    .oe_n(oen_l), .pipe(pipe_l), .word(word_l), .we(we_l),
    .dq(dout_l), .dq_oe(drive_l)
  );

  sdp_port #(.DATA_W(DATA_W)) u_right (
    .clk(clk_r), .rst_n(rst_r_n), .ce_n(ce0n_r), .ce(ce1_r), .rw(rw_r),
    .oe_n(oen_r), .pipe(pipe_r), .word(word_r), .we(we_r),
    .dq(dout_r), .dq_oe(drive_r)
  );

  sdp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_l(clk_l), .we_l(we_l), .addr_l(addr_l), .din_l(din_l), .word_l(word_l),
    .clk_r(clk_r), .we_r(we_r), .addr_r(addr_r), .din_r(din_r), .word_r(word_r)
  );

endmodule

// File: tb/sync_dpram_test.sv
`timescale 1ns/1ps
module sync_dpram_test;
  localparam int AW = 10;
  localparam int DW = 8;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{a: 10'h000, d: 8'hA1},
    '{a: 10'h001, d: 8'h3C},
    '{a: 10'h07F, d: 8'hFF},
    '{a: 10'h200, d: 8'h01},
    '{a: 10'h2AA, d: 8'h96},
    '{a: 10'h3FF, d: 8'h80}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic ce0n_l = 1'b1, ce1_l = 1'b1, rw_l = 1'b1, oen_l = 1'b0, pipe_l = 1'b0;
  logic ce0n_r = 1'b1, ce1_r = 1'b1, rw_r = 1'b1, oen_r = 1'b0, pipe_r = 1'b0;
  logic [AW-1:0] addr_l = '0, addr_r = '0;
  logic [DW-1:0] din_l = '0, din_r = '0;
  logic [DW-1:0] dout_l, dout_r;
  logic          drive_l, drive_r;

  sync_dpram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_l(clk), .rst_l_n(rst_n), .ce0n_l(ce0n_l), .ce1_l(ce1_l), .rw_l(rw_l),
    .oen_l(oen_l), .pipe_l(pipe_l), .addr_l(addr_l), .din_l(din_l),
    .dout_l(dout_l), .drive_l(drive_l),
    .clk_r(clk), .rst_r_n(rst_n), .ce0n_r(ce0n_r), .ce1_r(ce1_r), .rw_r(rw_r),
    .oen_r(oen_r), .pipe_r(pipe_r), .addr_r(addr_r), .din_r(din_r),
    .dout_r(dout_r), .drive_r(drive_r)
  );

  int runs = 0;
  int fails = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_l(); ce0n_l = 1'b1; ce1_l = 1'b1; rw_l = 1'b1; endtask
  task automatic idle_r(); ce0n_r = 1'b1; ce1_r = 1'b1; rw_r = 1'b1; endtask

  task automatic wr_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0n_l = 1'b0; ce1_l = 1'b1; rw_l = 1'b0; addr_l = a; din_l = d;
  endtask
  task automatic wr_r(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0n_r = 1'b0; ce1_r = 1'b1; rw_r = 1'b0; addr_r = a; din_r = d;
  endtask
  task automatic rd_l(input logic [AW-1:0] a);
    ce0n_l = 1'b0; ce1_l = 1'b1; rw_l = 1'b1; addr_l = a;
  endtask
  task automatic rd_r(input logic [AW-1:0] a);
    ce0n_r = 1'b0; ce1_r = 1'b1; rw_r = 1'b1; addr_r = a;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(); tick();
    chk("R1 left drive", {7'b0, drive_l}, 8'h00);
    chk("R1 left data", dout_l, 8'h00);
    chk("R1 right drive", {7'b0, drive_r}, 8'h00);
    chk("R1 right data", dout_r, 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", {7'b0, drive_l}, 8'h00);

    // table: write through left (R3), read through right (R4, R8)
    for (int i = 0; i < NV; i++) begin
      wr_l(VECS[i].a, VECS[i].d);
      tick();
    end
    idle_l();
    for (int i = 0; i < NV; i++) begin
      rd_r(VECS[i].a);
      tick();
      chk("R4 flow drive", {7'b0, drive_r}, 8'h01);
      chk("R8 cross-port data", dout_r, VECS[i].d);
    end
    idle_r();
    rd_l(VECS[4].a);
    tick();
    chk("R3 same-port readback", dout_l, VECS[4].d);
    idle_l();

    // R7 flow deselect
    tick();
    chk("R7 flow off after one edge", {7'b0, drive_l}, 8'h00);
    chk("R11 data zero when off", dout_l, 8'h00);

    // R2 partial select: no write, no drive
    ce0n_l = 1'b0; ce1_l = 1'b0; rw_l = 1'b0; addr_l = VECS[1].a; din_l = 8'hEE;
    tick();
    ce0n_l = 1'b0; ce1_l = 1'b0; rw_l = 1'b1;
    tick();
    chk("R2 enable1 low no drive", {7'b0, drive_l}, 8'h00);
    ce0n_l = 1'b1; ce1_l = 1'b1; rw_l = 1'b1;
    tick();
    chk("R2 both inactive no drive", {7'b0, drive_l}, 8'h00);
    rd_l(VECS[1].a);
    tick();
    chk("R2 write blocked", dout_l, VECS[1].d);
    idle_l();

    // R5 pipelined latency, R6 async enable, R7 pipelined deselect
    pipe_r = 1'b1;
    tick(); tick();
    rd_r(VECS[2].a);
    tick();
    chk("R5 not yet driving", {7'b0, drive_r}, 8'h00);
    idle_r();
    tick();
    chk("R5 pipelined drive", {7'b0, drive_r}, 8'h01);
    chk("R5 pipelined data", dout_r, VECS[2].d);
    oen_r = 1'b1;
    #0.5;
    chk("R6 enable high drops drive", {7'b0, drive_r}, 8'h00);
    chk("R6 enable high zero data", dout_r, 8'h00);
    oen_r = 1'b0;
    #0.5;
    chk("R6 enable low restores", dout_r, VECS[2].d);
    tick();
    chk("R7 pipelined off after two edges", {7'b0, drive_r}, 8'h00);
    chk("R11 pipelined zero", dout_r, 8'h00);
    tick();
    pipe_r = 1'b0;
    tick();

    // R9 same-address write collision
    wr_l(10'h3F0, 8'h11);
    wr_r(10'h3F0, 8'h22);
    tick();
    rd_l(10'h3F0);
    rd_r(10'h3F0);
    tick();
    chk("R9 right wins (right read)", dout_r, 8'h22);
    chk("R9 right wins (left read)", dout_l, 8'h22);
    idle_l(); idle_r();

    // R10 read during the other port's write
    wr_l(10'h155, 8'h5A);
    tick();
    rd_l(10'h155);
    wr_r(10'h155, 8'hA5);
    tick();
    chk("R10 old data returned", dout_l, 8'h5A);
    idle_r();
    tick();
    chk("R10 new data next read", dout_l, 8'hA5);
    idle_l();
    tick();

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule